// File: doc/BRIEF.md
# Register Side-Effect Log

This block keeps a short record of the general-register side effects caused by the instruction now running. The operand-decode logic reports every auto-increment or auto-decrement as an event: a 3-bit register number and a signed 5-bit change. The block packs up to two such events into one 16-bit word. When an instruction faults, a fault handler reads that word and uses it to undo the register changes before it restarts the instruction.

The word is cleared whenever a new instruction fetch begins. Each event gets its own byte, in arrival order. A slot counter inside the block picks the byte. Events are never merged by register number, so two changes to the same register produce two separate entries. The program counter (register 7) is logged the same way as any other register, for example when an immediate operand is fetched.

While the memory-management error status is latched, the word and its slot counter are frozen. The handler therefore sees the state of the faulting instruction.

Top module: `reg_effect_log`

## Requirements
- R1: After reset, rdData reads 0 and the next logged event goes into the low byte.
- R2: Each entry is 8 bits: bits [7:3] hold the register change as a 5-bit two's-complement value (+1 = 5'b00001, +2 = 5'b00010, -1 = 5'b11111, -2 = 5'b11110), and bits [2:0] hold the register number. Logged changes are always nonzero.
- R3: The first event after a clear is written to rdData[7:0]. rdData[15:8] stays 0. The change is visible one clock after the event.
- R4: The second event is written to rdData[15:8] and rdData[7:0] keeps its value, even when both events name the same register. Two events of +2 on register 7 read back as 16'o013427.
- R5: A third or later event in the same instruction has no effect on rdData.
- R6: When instStart is high, both bytes and the slot counter are cleared. An event in the same cycle is logged into rdData[7:0].
- R7: When errLatched is high, rdData and the slot counter do not change, whatever arrives on instStart or the event inputs.
- R8: In a cycle with no event and no instStart, rdData holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instStart | input | 1 | Start of an instruction fetch; clears the log |
| updValid | input | 1 | A register change event is present |
| updReg | input | 3 | Register number of the event |
| updDelta | input | 5 | Signed change of the event |
| errLatched | input | 1 | Memory-management error is latched; freezes the log |
| rdData | output | 16 | Current log word |

## Verification
A wrong slot counter shows at the ports within the next event or two. A counter that skips leaves the low byte empty. A counter that sticks overwrites byte 0 or fails to log the second event. A counter that wraps lets a third event overwrite byte 1. A clear or freeze that is applied wrongly shows on rdData one clock after the instStart or errLatched cycle. It can also show later, as an entry placed in the wrong byte after the freeze is released.

// File: rtl/reg_log_pkg.sv
package reg_log_pkg;
  parameter int REG_W   = 3;
  parameter int DELTA_W = 5;
  parameter int SLOTS   = 2;
  localparam int ENTRY_W = REG_W + DELTA_W;
  localparam int WORD_W  = ENTRY_W * SLOTS;
  localparam int CNT_W   = $clog2(SLOTS + 1);

  typedef struct packed {
    logic             clearAll;
    logic [SLOTS-1:0] wrSlot;
  } logStrobes_t;
endpackage

// File: rtl/reg_log_ctrl.sv
module reg_log_ctrl
  import reg_log_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instStart,
  input  logic        updValid,
  input  logic        freeze,
  output logStrobes_t strb
);
  logic [CNT_W-1:0] slotCnt;
  logic [CNT_W-1:0] baseCnt;

  assign baseCnt = instStart ? '0 : slotCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= '0;
    end else if (!freeze) begin
      if (updValid && baseCnt < CNT_W'(SLOTS)) slotCnt <= baseCnt + 1'b1;
      else                                      slotCnt <= baseCnt;
    end
  end

  assign strb.clearAll = instStart && !freeze;

  for (genvar i = 0; i < SLOTS; i++) begin : g_sel
    assign strb.wrSlot[i] = !freeze && updValid && (baseCnt == CNT_W'(i));
  end
endmodule

// File: rtl/reg_log_dp.sv
module reg_log_dp
  import reg_log_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logStrobes_t        strb,
  input  logic [REG_W-1:0]   updReg,
  input  logic [DELTA_W-1:0] updDelta,
  output logic [WORD_W-1:0]  logWord
);
  logic [ENTRY_W-1:0] newEntry;
  assign newEntry = {updDelta, updReg};

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [ENTRY_W-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN)               slotQ <= '0;
      else if (strb.wrSlot[i]) slotQ <= newEntry;
      else if (strb.clearAll)  slotQ <= '0;
    end
    assign logWord[i*ENTRY_W +: ENTRY_W] = slotQ;
  end
endmodule

// File: rtl/reg_effect_log.sv
module reg_effect_log
  import reg_log_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instStart,
  input  logic        updValid,
  input  logic [2:0]  updReg,
  input  logic [4:0]  updDelta,
  input  logic        errLatched,
  output logic [15:0] rdData
);
  logStrobes_t strb;

  reg_log_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instStart(instStart),
    .updValid(updValid), .freeze(errLatched), .strb(strb)
  );

  reg_log_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .updReg(updReg), .updDelta(updDelta), .logWord(rdData)
  );
endmodule

// File: rtl/reg_effect_log_chk.sv
module reg_effect_log_chk (
  input logic        clk,
  input logic        rstN,
  input logic        instStart,
  input logic        updValid,
  input logic [2:0]  updReg,
  input logic [4:0]  updDelta,
  input logic        errLatched,
  input logic [15:0] rdData
);
  // R7
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rstN)
    errLatched |=> $stable(rdData));
  // R6
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    (instStart && !errLatched && !updValid) |=> rdData == 16'h0);
  // R3 / R6
  a_r3_first_low: assert property (@(posedge clk) disable iff (!rstN)
    (instStart && !errLatched && updValid) |=>
      rdData == {8'h00, $past(updDelta), $past(updReg)});
  // R4
  a_r4_second_high: assert property (@(posedge clk) disable iff (!rstN)
    (!instStart && !errLatched && updValid && rdData[7:0] != 8'h0 && rdData[15:8] == 8'h0) |=>
      (rdData[7:0] == $past(rdData[7:0]) && rdData[15:8] == {$past(updDelta), $past(updReg)}));
  // R5
  a_r5_third_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!instStart && updValid && rdData[15:8] != 8'h0) |=> $stable(rdData));
  // R8
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!instStart && !updValid) |=> $stable(rdData));
endmodule

bind reg_effect_log reg_effect_log_chk i_chk (.*);

// File: tb/test_reg_effect_log.sv
module test_reg_effect_log;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instStart = 1'b0;
  logic        updValid = 1'b0;
  logic [2:0]  updReg = '0;
  logic [4:0]  updDelta = '0;
  logic        errLatched = 1'b0;
  logic [15:0] rdData;

  int checks = 0;
  int errors = 0;
  logic [15:0] mWord = '0;
  int          mCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_effect_log i_reg_effect_log (.*);

  function automatic logic [4:0] pickDelta(int k);
    case (k % 4)
      0: return 5'b00001;
      1: return 5'b00010;
      2: return 5'b11111;
      default: return 5'b11110;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] exp);
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s: rdData=%o expected=%o", tag, rdData, exp);
    end
  endtask

  task automatic step(logic st, logic uv, logic [2:0] r, logic [4:0] d, logic er);
    string tag;
    @(negedge clk);
    instStart = st; updValid = uv; updReg = r; updDelta = d; errLatched = er;
    if (er)                      tag = "R7";
    else if (st)                 tag = "R6";
    else if (!uv)                tag = "R8";
    else if (mCnt == 0)          tag = "R3";
    else if (mCnt == 1)          tag = "R4";
    else                         tag = "R5";
    if (!er) begin
      if (st) begin mWord = '0; mCnt = 0; end
      if (uv && mCnt < 2) begin
        mWord[mCnt*8 +: 8] = {d, r};
        mCnt++;
      end
    end
    @(posedge clk); #1;
    check(tag, mWord);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: expired actual=running expected=done");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    repeat (3) @(posedge clk);
    #1;
    check("R1", 16'h0);
    @(negedge clk); rstN = 1'b1;

    // R2 R4: two +2 updates of register 7 -> 013427
    step(1, 0, 0, 0, 0);
    step(0, 1, 3'd7, 5'b00010, 0);
    step(0, 1, 3'd7, 5'b00010, 0);
    check("R4", 16'o013427);
    // R5: third update ignored
    step(0, 1, 3'd2, 5'b11110, 0);
    // R7: frozen against start and update
    step(1, 1, 3'd1, 5'b00001, 1);
    step(0, 0, 0, 0, 0);
    // R6: start with simultaneous update goes to byte 0
    step(1, 1, 3'd3, 5'b11111, 0);
    check("R6", {8'h00, 5'b11111, 3'd3});
    step(0, 0, 0, 0, 0);

    // random instructions
    for (int n = 0; n < 600; n++) begin
      int nUpd;
      logic er;
      nUpd = $urandom_range(0, 3);
      er = ($urandom_range(0, 7) == 0);
      step(1, $urandom_range(0, 3) == 0, 3'($urandom), pickDelta($urandom), er);
      for (int k = 0; k < nUpd; k++) begin
        if ($urandom_range(0, 2) == 0) step(0, 0, 0, 0, er);
        step(0, 1, 3'($urandom), pickDelta($urandom), er);
      end
    end
    summary();
  end
endmodule